// File: doc/BRIEF.md
# Count-Driven Word-Unpacking Serial Transmitter

This block sends a counted run of 8-bit characters over an asynchronous serial line. Software first programs the number of characters in the transfer, then writes 32-bit words into a small transmit FIFO, each word carrying up to four characters. The block takes words from the FIFO, splits them into characters and shifts each one out as a start bit, eight data bits and a stop bit. A character counter, not per-byte flags, decides where the transfer ends, so a partly filled last word is cut off exactly at the programmed count.

The bit timing comes from an external oversampling tick; every bit on the line lasts sixteen ticks. Status outputs report whether the FIFO can take another word and whether the whole transmit path is idle. A ready interrupt marks the moment the final word of the counted transfer leaves the FIFO, and a watermark interrupt follows the FIFO fill level against a programmable threshold. A small command port resets the transmit path, clears the error flag and clears the ready interrupt.

Top module: `cntx_uart_tx`

## Requirements
- R1: Each character is framed as one low start bit, eight data bits with the least significant bit first, and one high stop bit; each bit lasts 16 `baud_tick` pulses and the line idles high.
- R2: Characters leave in byte order 0 (bits 7:0) to 3 (bits 31:24) of each word; once the programmed count is reached, the remaining bytes of the last word are discarded, so exactly `count` characters appear on the line.
- R3: A count write (`cnt_wr`) takes effect only while `tx_empty` is 1; a count write while `tx_empty` is 0 is discarded and sets `tx_err`.
- R4: A word written after the programmed count has been fully accepted into the FIFO (or before any count since reset or a transmit reset) is ignored: the FIFO level does not change and `tx_err` is not set.
- R5: `fifo_has_space` is 1 exactly when `fifo_level` is below the FIFO depth (4 words by default); a word arriving when the FIFO is full is dropped and sets `tx_err`.
- R6: `tx_empty` is 1 only when the FIFO is empty, no word is being unpacked and the line is idle high.
- R7: `irq_tx_ready` is set in the cycle after the word holding the last counted character is taken from the FIFO and stays set until command code 3 clears it; a set in the same cycle wins over the clear.
- R8: `irq_watermark` is 1 whenever `fifo_level` is less than or equal to the watermark threshold; the threshold is loaded by `wm_wr` and is 0 after reset.
- R9: Command code 1 (reset transmitter) empties the FIFO, drops any remaining count and word in progress and returns the line to idle high on the next cycle.
- R10: Command code 2 clears `tx_err`; command codes other than 1, 2 and 3 have no effect on any output.
- R11: After reset `txd`, `tx_empty`, `fifo_has_space` and `irq_watermark` are 1, and `tx_err`, `irq_tx_ready` and `fifo_level` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| wr_word_valid | input | 1 | Write strobe for a transmit word |
| wr_word | input | 32 | Four packed characters, byte 0 sent first |
| cnt_wr | input | 1 | Write strobe for the character count |
| cnt_val | input | CNT_W (16) | Number of characters in the transfer |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Command: 1 reset transmitter, 2 clear error, 3 clear ready interrupt |
| wm_wr | input | 1 | Write strobe for the watermark threshold |
| wm_val | input | LVL_W (3) | Watermark threshold in words |
| txd | output | 1 | Serial line output |
| fifo_has_space | output | 1 | FIFO can take one more word |
| tx_empty | output | 1 | FIFO empty and transmitter idle |
| tx_err | output | 1 | Sticky transmit error |
| irq_tx_ready | output | 1 | Counted transfer fully taken from the FIFO |
| irq_watermark | output | 1 | FIFO level at or below the threshold |
| fifo_level | output | LVL_W (3) | Words held in the FIFO |

## Verification
Every cycle, assertions confirm that the line sits high whenever the path reports empty, that a start bit follows each character load and a stop bit follows the eighth data bit, that a rejected count write raises the error flag, that ignored and overflowing words leave the FIFO level unchanged, that a transmit reset empties the path and that a lone clear command drops the ready interrupt. Only the bench scenarios show the characters decoded from the line, their order within the word, the truncation of the last word at the programmed count, the watermark comparison at several thresholds and the silence of unknown command codes.

// File: rtl/cntx_pkg.sv
package cntx_pkg;

  localparam logic [3:0] CMD_TX_RESET  = 4'd1;
  localparam logic [3:0] CMD_ERR_CLEAR = 4'd2;
  localparam logic [3:0] CMD_RDY_CLEAR = 4'd3;

  localparam int BYTES_PER_WORD = 4;

  typedef enum logic [1:0] {
    SER_IDLE  = 2'd0,
    SER_START = 2'd1,
    SER_DATA  = 2'd2,
    SER_STOP  = 2'd3
  } ser_state_t;

  // Characters a word carries when 'left' characters are still owed.
  function automatic logic [2:0] chars_in_word(input logic [15:0] left);
    if (left >= 16'(BYTES_PER_WORD)) return 3'(BYTES_PER_WORD);
    return left[2:0];
  endfunction

  // Byte 'idx' of a packed word, byte 0 in the low bits.
  function automatic logic [7:0] pick_byte(input logic [31:0] word,
                                           input logic [1:0]  idx);
    return word[8*idx +: 8];
  endfunction

endpackage

// File: rtl/cntx_word_fifo.sv
module cntx_word_fifo #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              empty
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              push_fire, pop_fire;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign full      = (level == LVL_W'(DEPTH));
  assign empty     = (level == '0);
  assign push_fire = push && !full;
  assign pop_fire  = pop && !empty;
  assign dout      = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_fire) wr_ptr <= ptr_next(wr_ptr);
      if (pop_fire)  rd_ptr <= ptr_next(rd_ptr);
      if (push_fire && !pop_fire)      level <= level + 1'b1;
      else if (pop_fire && !push_fire) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_ptr] <= din;
  end

  // R5: a push into a full FIFO with no pop leaves the level untouched
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (level == LVL_W'(DEPTH)));

  assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

endmodule

// File: rtl/cntx_unpacker.sv
module cntx_unpacker
  import cntx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             word_wr,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  input  logic [31:0]      fifo_dout,
  output logic             push,
  output logic             overflow,
  output logic             pop,
  output logic             final_pop,
  output logic             char_vld,
  output logic [7:0]       char_data,
  input  logic             char_rdy,
  output logic             hold_busy,
  output logic             acc_zero
);

  logic [CNT_W-1:0] acc_left;   // characters still to be accepted as words
  logic [CNT_W-1:0] snd_left;   // characters still to be taken from FIFO
  logic [31:0]      hold_word;
  logic [2:0]       hold_n;
  logic [1:0]       bidx;
  logic             hold_vld;
  logic             accept;
  logic             char_fire;
  logic             last_in_word;
  logic [2:0]       acc_take, snd_take;

  assign acc_take     = chars_in_word(16'(acc_left));
  assign snd_take     = chars_in_word(16'(snd_left));
  assign acc_zero     = (acc_left == '0);
  assign accept       = word_wr && !acc_zero;
  assign push         = accept && !fifo_full;
  assign overflow     = accept && fifo_full;
  assign pop          = !hold_vld && !fifo_empty && (snd_left != '0);
  assign final_pop    = pop && (snd_left <= CNT_W'(BYTES_PER_WORD));
  assign char_vld     = hold_vld;
  assign char_data    = pick_byte(hold_word, bidx);
  assign char_fire    = hold_vld && char_rdy;
  assign last_in_word = ({1'b0, bidx} + 3'd1) == hold_n;
  assign hold_busy    = hold_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_left <= '0;
      snd_left <= '0;
    end else if (flush) begin
      acc_left <= '0;
      snd_left <= '0;
    end else if (cnt_load) begin
      acc_left <= cnt_val;
      snd_left <= cnt_val;
    end else begin
      if (push) acc_left <= acc_left - CNT_W'(acc_take);
      if (pop)  snd_left <= snd_left - CNT_W'(snd_take);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld  <= 1'b0;
      hold_word <= '0;
      hold_n    <= '0;
      bidx      <= '0;
    end else if (flush) begin
      hold_vld <= 1'b0;
      bidx     <= '0;
    end else if (pop) begin
      hold_vld  <= 1'b1;
      hold_word <= fifo_dout;
      hold_n    <= snd_take;
      bidx      <= '0;
    end else if (char_fire) begin
      if (last_in_word) begin
        hold_vld <= 1'b0;
        bidx     <= '0;
      end else begin
        bidx <= bidx + 1'b1;
      end
    end
  end

  // R2: a held word never claims more than four characters nor zero
  assert_hold_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_vld |-> (hold_n != 3'd0 && hold_n <= 3'd4));

  // R2: byte index stays inside the counted part of the word
  assert_byte_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_vld |-> ({1'b0, bidx} < hold_n));

endmodule

// File: rtl/cntx_serializer.sv
module cntx_serializer
  import cntx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8,
  localparam int TC_W      = $clog2(OVERSAMPLE),
  localparam int BI_W      = $clog2(DATA_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 abort,
  input  logic                 tick,
  input  logic                 ld_vld,
  input  logic [DATA_BITS-1:0] ld_data,
  output logic                 ld_rdy,
  output logic                 idle,
  output logic                 txd
);

  ser_state_t           state;
  logic [TC_W-1:0]      tcnt;
  logic [BI_W-1:0]      bit_i;
  logic [DATA_BITS-1:0] shreg;
  logic                 bit_end;
  logic                 ld_fire;

  assign bit_end = tick && (tcnt == TC_W'(OVERSAMPLE - 1));
  assign idle    = (state == SER_IDLE);
  assign ld_rdy  = idle;
  assign ld_fire = ld_vld && idle;

  always_comb begin
    unique case (state)
      SER_START: txd = 1'b0;
      SER_DATA:  txd = shreg[0];
      default:   txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SER_IDLE;
      tcnt  <= '0;
      bit_i <= '0;
      shreg <= '0;
    end else if (abort) begin
      state <= SER_IDLE;
      tcnt  <= '0;
      bit_i <= '0;
    end else begin
      unique case (state)
        SER_IDLE: begin
          if (ld_vld) begin
            shreg <= ld_data;
            state <= SER_START;
            tcnt  <= '0;
            bit_i <= '0;
          end
        end
        SER_START: begin
          if (tick) tcnt <= tcnt + 1'b1;
          if (bit_end) state <= SER_DATA;
        end
        SER_DATA: begin
          if (tick) tcnt <= tcnt + 1'b1;
          if (bit_end) begin
            shreg <= shreg >> 1;
            if (bit_i == BI_W'(DATA_BITS - 1)) state <= SER_STOP;
            else bit_i <= bit_i + 1'b1;
          end
        end
        default: begin
          if (tick) tcnt <= tcnt + 1'b1;
          if (bit_end) state <= SER_IDLE;
        end
      endcase
    end
  end

  // R1: a loaded character starts with a low start bit on the next cycle
  assert_start_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fire && !abort) |=> !txd);

  // R1: after the last data bit the line carries a high stop bit
  assert_stop_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SER_DATA && bit_end && bit_i == BI_W'(DATA_BITS - 1) && !abort) |=> txd);

endmodule

// File: rtl/cntx_uart_tx.sv
module cntx_uart_tx
  import cntx_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DEPTH      = 4,
  parameter int OVERSAMPLE = 16,
  localparam int LVL_W     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic             wr_word_valid,
  input  logic [31:0]      wr_word,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_code,
  input  logic             wm_wr,
  input  logic [LVL_W-1:0] wm_val,
  output logic             txd,
  output logic             fifo_has_space,
  output logic             tx_empty,
  output logic             tx_err,
  output logic             irq_tx_ready,
  output logic             irq_watermark,
  output logic [LVL_W-1:0] fifo_level
);

  // named internal events
  logic        cmd_reset, cmd_err_clr, cmd_rdy_clr;
  logic        cnt_load, cnt_reject;
  logic        fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [31:0] fifo_dout;
  logic        overflow, final_pop;
  logic        char_vld, char_rdy;
  logic [7:0]  char_data;
  logic        hold_busy, acc_zero, ser_idle;
  logic [LVL_W-1:0] wm_reg;

  assign cmd_reset   = cmd_valid && (cmd_code == CMD_TX_RESET);
  assign cmd_err_clr = cmd_valid && (cmd_code == CMD_ERR_CLEAR);
  assign cmd_rdy_clr = cmd_valid && (cmd_code == CMD_RDY_CLEAR);

  assign tx_empty       = fifo_empty && !hold_busy && ser_idle;
  assign cnt_load       = cnt_wr && tx_empty && !cmd_reset;
  assign cnt_reject     = cnt_wr && !tx_empty && !cmd_reset;
  assign fifo_has_space = !fifo_full;
  assign irq_watermark  = (fifo_level <= wm_reg);

  cntx_word_fifo #(.DEPTH(DEPTH), .DATA_W(32)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (cmd_reset),
    .push  (fifo_push),
    .din   (wr_word),
    .pop   (fifo_pop),
    .dout  (fifo_dout),
    .level (fifo_level),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  cntx_unpacker #(.CNT_W(CNT_W)) u_unpack (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (cmd_reset),
    .cnt_load   (cnt_load),
    .cnt_val    (cnt_val),
    .word_wr    (wr_word_valid && !cmd_reset),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .fifo_dout  (fifo_dout),
    .push       (fifo_push),
    .overflow   (overflow),
    .pop        (fifo_pop),
    .final_pop  (final_pop),
    .char_vld   (char_vld),
    .char_data  (char_data),
    .char_rdy   (char_rdy),
    .hold_busy  (hold_busy),
    .acc_zero   (acc_zero)
  );

  cntx_serializer #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(8)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort   (cmd_reset),
    .tick    (baud_tick),
    .ld_vld  (char_vld),
    .ld_data (char_data),
    .ld_rdy  (char_rdy),
    .idle    (ser_idle),
    .txd     (txd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_err       <= 1'b0;
      irq_tx_ready <= 1'b0;
      wm_reg       <= '0;
    end else begin
      if (overflow || cnt_reject) tx_err <= 1'b1;
      else if (cmd_err_clr)       tx_err <= 1'b0;
      if (final_pop && !cmd_reset) irq_tx_ready <= 1'b1;
      else if (cmd_rdy_clr)        irq_tx_ready <= 1'b0;
      if (wm_wr) wm_reg <= wm_val;
    end
  end

  // R6: an empty path keeps the line at idle high
  assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);

  // R3: a count write while busy raises the error flag
  assert_count_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !tx_empty && !cmd_reset) |=> tx_err);

  // R4: a word beyond the count leaves the FIFO level as it was
  assert_ignored_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word_valid && acc_zero && !cnt_load && !fifo_pop && !cmd_reset)
      |=> (fifo_level == $past(fifo_level)));

  // R9: reset-transmitter command returns the whole path to empty
  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (tx_empty && txd && fifo_level == '0));

  // R7: a clear with no new completion drops the ready interrupt
  assert_rdy_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rdy_clr && !final_pop) |=> !irq_tx_ready);

  // R10: clear-error with no new error drops the flag
  assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_err_clr && !overflow && !cnt_reject) |=> !tx_err);

endmodule

// File: tb/cntx_uart_tx_test.sv
`timescale 1ns/1ps
module cntx_uart_tx_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        baud_tick = 1'b0;
  logic        wr_word_valid = 1'b0;
  logic [31:0] wr_word = '0;
  logic        cnt_wr = 1'b0;
  logic [15:0] cnt_val = '0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_code = '0;
  logic        wm_wr = 1'b0;
  logic [2:0]  wm_val = '0;
  logic        txd, fifo_has_space, tx_empty, tx_err, irq_tx_ready, irq_watermark;
  logic [2:0]  fifo_level;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  cntx_uart_tx uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .wr_word_valid(wr_word_valid), .wr_word(wr_word),
    .cnt_wr(cnt_wr), .cnt_val(cnt_val),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .wm_wr(wm_wr), .wm_val(wm_val),
    .txd(txd), .fifo_has_space(fifo_has_space), .tx_empty(tx_empty),
    .tx_err(tx_err), .irq_tx_ready(irq_tx_ready),
    .irq_watermark(irq_watermark), .fifo_level(fifo_level)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FIFO-TX FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // tick generator and line monitor, both on the falling edge
  bit       tdiv = 1'b0;
  bit       mon_en = 1'b1;
  bit       mon_busy = 1'b0;
  int       mcnt = 0;
  logic [7:0] mbyte;
  logic [7:0] rx_buf [64];
  int       rx_n = 0;

  always @(negedge clk) begin
    if (mon_en && mon_busy && baud_tick) begin
      mcnt = mcnt + 1;
      if (mcnt == 8) chk(txd == 1'b0, "R1 start bit", txd, 0);
      else if (mcnt > 8 && mcnt < 152 && ((mcnt - 8) % 16) == 0)
        mbyte[(mcnt - 8) / 16 - 1] = txd;
      else if (mcnt == 152) begin
        chk(txd == 1'b1, "R1 stop bit", txd, 1);
        if (rx_n < 64) rx_buf[rx_n] = mbyte;
        rx_n = rx_n + 1;
        mon_busy = 1'b0;
      end
    end else if (mon_en && !mon_busy && rst_n && txd == 1'b0) begin
      mon_busy = 1'b1;
      mcnt = 0;
    end
    if (!mon_en) mon_busy = 1'b0;
    tdiv = ~tdiv;
    baud_tick <= tdiv;
  end

  task automatic write_count(input int n);
    @(negedge clk); cnt_wr = 1'b1; cnt_val = 16'(n);
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic write_word(input logic [31:0] w);
    wr_word_valid = 1'b1; wr_word = w;
    @(negedge clk); wr_word_valid = 1'b0;
  endtask

  task automatic command(input logic [3:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (!(tx_empty && !mon_busy) && guard < 20000) begin
      @(negedge clk); guard++;
    end
    repeat (40) @(negedge clk);
  endtask

  // table: count, word 0, word 1
  localparam int NVEC = 6;
  localparam logic [71:0] VEC [NVEC] = '{
    {8'd1, 32'hDDCCBBA5, 32'h11111111},
    {8'd3, 32'h44332211, 32'h99999999},
    {8'd4, 32'h807F0100, 32'h77777777},
    {8'd5, 32'hF0E1D2C3, 32'h6655443C},
    {8'd8, 32'h0F1E2D3C, 32'h4B5A6978},
    {8'd6, 32'h13579BDF, 32'h2468ACE0}
  };

  function automatic logic [7:0] exp_byte(input logic [31:0] w0, input logic [31:0] w1,
                                          input int i);
    logic [63:0] both;
    both = {w1, w0};
    return both[8*i +: 8];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FIFO-TX FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(txd == 1'b1, "R11 txd", txd, 1);
    chk(tx_empty == 1'b1, "R11 tx_empty", tx_empty, 1);
    chk(fifo_has_space == 1'b1, "R11 space", fifo_has_space, 1);
    chk(irq_watermark == 1'b1, "R11 watermark", irq_watermark, 1);
    chk(tx_err == 1'b0 && irq_tx_ready == 1'b0 && fifo_level == 0, "R11 flags",
        {tx_err, irq_tx_ready, fifo_level}, 0);

    // R4: a word before any count is ignored
    @(negedge clk); write_word(32'hCAFEF00D);
    chk(fifo_level == 0 && tx_err == 1'b0, "R4 word before count", fifo_level, 0);

    // table walk: R1, R2, R4, R7
    for (int v = 0; v < NVEC; v++) begin
      int n;
      logic [31:0] w0, w1;
      n  = int'(VEC[v][71:64]);
      w0 = VEC[v][63:32];
      w1 = VEC[v][31:0];
      rx_n = 0;
      write_count(n);
      write_word(w0);
      write_word(w1);
      chk(fifo_level == 3'((n > 4) ? 1 : 0), "R4 level after second word",
          fifo_level, (n > 4) ? 1 : 0);
      chk(tx_err == 1'b0, "R4 no error", tx_err, 0);
      wait_idle();
      chk(rx_n == n, "R2 character count", rx_n, n);
      for (int i = 0; i < n && i < rx_n; i++)
        chk(rx_buf[i] == exp_byte(w0, w1, i), "R2 R1 character", rx_buf[i], exp_byte(w0, w1, i));
      chk(irq_tx_ready == 1'b1, "R7 ready set", irq_tx_ready, 1);
      command(4'd3);
      chk(irq_tx_ready == 1'b0, "R7 ready cleared", irq_tx_ready, 0);
    end

    // R3: count written while busy is discarded and flags an error
    rx_n = 0;
    write_count(2);
    write_word(32'h00005A3C);
    write_count(9);
    chk(tx_err == 1'b1, "R3 reject sets error", tx_err, 1);
    write_word(32'h12345678);
    chk(fifo_level == 0, "R3 old count kept, extra word ignored", fifo_level, 0);
    wait_idle();
    chk(rx_n == 2, "R3 characters sent", rx_n, 2);

    // R10: unknown codes change nothing, code 2 clears the error
    command(4'd0);
    command(4'd7);
    chk(tx_err == 1'b1 && irq_tx_ready == 1'b1, "R10 unknown codes",
        {tx_err, irq_tx_ready}, 3);
    chk(tx_empty == 1'b1 && txd == 1'b1, "R10 line untouched", {tx_empty, txd}, 3);
    command(4'd2);
    chk(tx_err == 1'b0 && irq_tx_ready == 1'b1, "R10 error clear only",
        {tx_err, irq_tx_ready}, 1);
    command(4'd3);

    // R5 / R8: fill the FIFO, overflow, watermark thresholds
    mon_en = 1'b0;
    wm_wr = 1'b1; wm_val = 3'd3;
    @(negedge clk); wm_wr = 1'b0;
    chk(irq_watermark == 1'b1, "R8 level 0 under 3", irq_watermark, 1);
    write_count(40);
    for (int k = 0; k < 5; k++) write_word(32'h01010101 * (k + 1));
    chk(fifo_level == 4, "R5 full level", fifo_level, 4);
    chk(fifo_has_space == 1'b0, "R5 no space", fifo_has_space, 0);
    chk(irq_watermark == 1'b0, "R8 level 4 above 3", irq_watermark, 0);
    chk(tx_err == 1'b0, "R5 no error yet", tx_err, 0);
    write_word(32'hEEEEEEEE);
    chk(tx_err == 1'b1 && fifo_level == 4, "R5 overflow dropped", fifo_level, 4);
    wm_wr = 1'b1; wm_val = 3'd4;
    @(negedge clk); wm_wr = 1'b0;
    chk(irq_watermark == 1'b1, "R8 level 4 at 4", irq_watermark, 1);
    chk(irq_tx_ready == 1'b0, "R7 not set mid transfer", irq_tx_ready, 0);

    // R9: reset transmitter
    @(negedge clk); cmd_valid = 1'b1; cmd_code = 4'd1;
    @(negedge clk); cmd_valid = 1'b0;
    chk(fifo_level == 0 && tx_empty == 1'b1, "R9 flushed", fifo_level, 0);
    chk(txd == 1'b1, "R9 line idle", txd, 1);
    chk(fifo_has_space == 1'b1, "R5 space after flush", fifo_has_space, 1);
    write_word(32'h55555555);
    chk(fifo_level == 0, "R9 count dropped", fifo_level, 0);
    repeat (400) @(negedge clk);
    chk(txd == 1'b1 && tx_empty == 1'b1, "R9 stays idle", txd, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule